// File: doc/BRIEF.md
# UART Receive Character-Timeout Detector

This block sits beside a UART receive FIFO and decides when data has been left waiting too long. Whenever the FIFO holds at least one word, it counts baud-rate bit ticks. A received character restarts the count, and so does a host read of the receive holding register. When the count reaches four character times, it raises a timeout interrupt. The host can then drain a partial FIFO that will never reach its trigger level. The trigger level plays no part in the decision.

A character time is the number of bits in one frame under the current line settings: one start bit, plus the data bits, plus an optional parity bit, plus the stop bits. Because the span is counted in bit ticks, it follows the baud rate automatically. A change to the frame format takes effect at once.

Top module: `rx_idle_timeout`

## Requirements
- R1: While `fifo_nonempty_i` is low, the idle count is held at zero and `timeout_irq_o` never sets, however many bit ticks arrive.
- R2: Character length in bits is 1 + (5 + `data_len_i`) + `parity_en_i` + stop bits. `data_len_i` codes 0..3 mean 5..8 data bits. `stop_sel_i` code 0 means 1 stop bit; code 1 (1.5 stop bits) counts as 2; codes 2 and 3 mean 2 stop bits.
- R3: With the FIFO non-empty and no restart, `timeout_irq_o` is high in the cycle after the 4 × (character length)-th bit tick, and low after any smaller number of ticks.
- R4: A `char_rcvd_i` pulse restarts the count from zero, so a full new span of ticks is needed before the timeout fires.
- R5: A `host_rd_i` pulse restarts the count from zero and clears `timeout_irq_o` in the following cycle.
- R6: `timeout_irq_o` clears in the cycle after `fifo_nonempty_i` is seen low.
- R7: Once set, `timeout_irq_o` stays high through further bit ticks and through a `char_rcvd_i` pulse, until a clear of R5 or R6.
- R8: A restart (received character or host read) in the same cycle as a bit tick wins: that tick is not counted.
- R9: The span always uses the current format. If the format shrinks below the count already reached, the timeout fires on the next bit tick, not on the format change itself.
- R10: Synchronous active-low reset clears the count and `timeout_irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_nonempty_i | input | 1 | Receive FIFO holds at least one word |
| char_rcvd_i | input | 1 | One-cycle pulse: a character was written into the FIFO |
| host_rd_i | input | 1 | One-cycle pulse: host read the receive holding register |
| bit_tick_i | input | 1 | One-cycle pulse per bit time at the current baud rate |
| data_len_i | input | 2 | Data bits minus five |
| parity_en_i | input | 1 | Parity bit present |
| stop_sel_i | input | 2 | Stop-bit setting (see R2) |
| timeout_irq_o | output | 1 | Character-timeout interrupt flag |

## Verification
The hardest situation to reach from the ports is a format change while the count sits between the new, shorter limit and the old one. In that state the detector must wait for one more tick rather than fire on the setting change. The bench sets up a long frame, feeds thirty ticks, and switches to the shortest frame. It then checks that the flag stays low until the next tick and is high right after it. A same-cycle restart and tick is driven deliberately, and the bench confirms that a whole new span is then required.

// File: rtl/rxto_pkg.sv
// Package: shared types and the frame-length function for the receive
// character-timeout detector. Assumes data lengths of 5..8 bits.
package rxto_pkg;

    // Stop-bit setting codes as seen on the line-control input.
    typedef enum logic [1:0] {
        STOP_ONE      = 2'd0,
        STOP_ONE_HALF = 2'd1,
        STOP_TWO      = 2'd2,
        STOP_TWO_ALT  = 2'd3
    } stop_sel_t;

    localparam int unsigned MIN_DATA_BITS = 5;
    localparam int unsigned MAX_CHAR_BITS = 1 + 8 + 1 + 2;
    localparam int unsigned CHAR_BITS_W   = $clog2(MAX_CHAR_BITS + 1);

    // Bits per frame: start + data + parity + stop (1.5 stop rounded up).
    function automatic logic [CHAR_BITS_W-1:0] frame_bits(
        input logic [1:0] data_len,
        input logic       parity_en,
        input stop_sel_t  stop_sel
    );
        logic [CHAR_BITS_W-1:0] stop_bits;
        stop_bits = (stop_sel == STOP_ONE) ? CHAR_BITS_W'(1) : CHAR_BITS_W'(2);
        return CHAR_BITS_W'(1) + CHAR_BITS_W'(MIN_DATA_BITS)
             + CHAR_BITS_W'(data_len) + CHAR_BITS_W'(parity_en) + stop_bits;
    endfunction

endpackage

// File: rtl/rxto_frame_len.sv
// Module: rxto_frame_len
// Turns the line-control fields into the timeout span in bit ticks
// (CHAR_SPAN character times). Purely combinational; assumes the fields
// are stable or that a change should apply immediately.
module rxto_frame_len
    import rxto_pkg::*;
#(
    parameter int unsigned CHAR_SPAN = 4,
    parameter int unsigned CNT_W     = $clog2(CHAR_SPAN * MAX_CHAR_BITS + 1)
) (
    input  logic [1:0]       data_len_i,
    input  logic             parity_en_i,
    input  logic [1:0]       stop_sel_i,
    output logic [CNT_W-1:0] span_o
);
    localparam bit SPAN_POW2  = (CHAR_SPAN & (CHAR_SPAN - 1)) == 0;
    localparam int unsigned SPAN_SHIFT = $clog2(CHAR_SPAN);

    logic [CHAR_BITS_W-1:0] char_bits;

    // Bits in one frame under the current format.
    always_comb char_bits = frame_bits(data_len_i, parity_en_i, stop_sel_t'(stop_sel_i));

    // Scale to the span: a shift when the span count is a power of two.
    generate
        if (SPAN_POW2) begin : g_shift
            always_comb span_o = CNT_W'(char_bits) << SPAN_SHIFT;
        end else begin : g_mult
            always_comb span_o = CNT_W'(char_bits) * CNT_W'(CHAR_SPAN);
        end
    endgenerate

endmodule

// File: rtl/rxto_bit_counter.sv
// Module: rxto_bit_counter
// Counts bit ticks while the FIFO is non-empty and no restart is seen,
// saturating at the span. Emits a one-cycle fire pulse on the tick that
// reaches (or passes, after a format shrink) the span. Restart wins
// over a same-cycle tick.
module rxto_bit_counter #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] span_i,
    output logic             fire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_next;

    // Value the count would take on an accepted tick.
    always_comb cnt_next = {1'b0, cnt_q} + (CNT_W+1)'(1);

    // Fire when an accepted tick reaches the current span.
    always_comb fire_o = !restart_i && tick_i && (cnt_next >= {1'b0, span_i});

    // Idle bit-tick counter with restart priority and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q < span_i)) begin
            cnt_q <= cnt_next[CNT_W-1:0];
        end
    end

    // R1, R4, R5, R8: any restart leaves the count at zero next cycle.
    a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0));

    // R3: the count never moves by more than one per cycle.
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(restart_i) |-> (cnt_q <= $past(cnt_q) + CNT_W'(1)));

    // R3: without a tick the count cannot grow.
    a_r3_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart_i) |=> $stable(cnt_q));

endmodule

// File: rtl/rxto_irq_flag.sv
// Module: rxto_irq_flag
// Sticky timeout flag: set by the counter's fire pulse, cleared by a host
// read or an empty FIFO. A received character does not clear it.
module rxto_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic host_rd_i,
    input  logic fifo_empty_i,
    output logic irq_o
);
    // Hold the interrupt until the host reads or the FIFO drains.
    always_ff @(posedge clk) begin
        if (!rst_n || host_rd_i || fifo_empty_i) begin
            irq_o <= 1'b0;
        end else if (fire_i) begin
            irq_o <= 1'b1;
        end
    end

    // R5: a host read clears the flag.
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_i |=> !irq_o);

    // R6: an empty FIFO clears the flag.
    a_r6_empty_clears: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty_i |=> !irq_o);

    // R7: a set flag stays set unless a clear condition was present.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !host_rd_i && !fifo_empty_i) |=> irq_o);

endmodule

// File: rtl/rx_idle_timeout.sv
// Module: rx_idle_timeout (top)
// Receive character-timeout detector. Raises timeout_irq_o when the FIFO
// has held data for CHAR_SPAN character times of bit ticks with no new
// character and no host read. Assumes all pulse inputs are synchronous
// to clk and one cycle wide.
module rx_idle_timeout
    import rxto_pkg::*;
#(
    parameter int unsigned CHAR_SPAN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_nonempty_i,
    input  logic       char_rcvd_i,
    input  logic       host_rd_i,
    input  logic       bit_tick_i,
    input  logic [1:0] data_len_i,
    input  logic       parity_en_i,
    input  logic [1:0] stop_sel_i,
    output logic       timeout_irq_o
);
    localparam int unsigned MAX_SPAN = CHAR_SPAN * MAX_CHAR_BITS;
    localparam int unsigned CNT_W    = $clog2(MAX_SPAN + 1);

    logic [CNT_W-1:0] span;
    logic             restart;
    logic             fire;

    // Any activity, or an empty FIFO, restarts the idle count.
    always_comb restart = !fifo_nonempty_i || char_rcvd_i || host_rd_i;

    rxto_frame_len #(
        .CHAR_SPAN (CHAR_SPAN),
        .CNT_W     (CNT_W)
    ) i_frame_len (
        .data_len_i  (data_len_i),
        .parity_en_i (parity_en_i),
        .stop_sel_i  (stop_sel_i),
        .span_o      (span)
    );

    rxto_bit_counter #(
        .CNT_W (CNT_W)
    ) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .tick_i    (bit_tick_i),
        .span_i    (span),
        .fire_o    (fire)
    );

    rxto_irq_flag i_flag (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire_i       (fire),
        .host_rd_i    (host_rd_i),
        .fifo_empty_i (!fifo_nonempty_i),
        .irq_o        (timeout_irq_o)
    );

    // R3, R8: the flag only rises after a tick with data and no restart.
    a_r3_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_irq_o) |-> ($past(bit_tick_i) && $past(fifo_nonempty_i)
                                  && !$past(char_rcvd_i) && !$past(host_rd_i)));

    // R1: no flag is raised while the FIFO is empty.
    a_r1_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_nonempty_i |=> !timeout_irq_o);

    // R10: reset leaves the flag low.
    a_r10_reset_low: assert property (@(posedge clk)
        !rst_n |=> !timeout_irq_o);

endmodule

// File: tb/test_rx_idle_timeout.sv
module test_rx_idle_timeout;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_nonempty_i = 1'b0;
    logic       char_rcvd_i = 1'b0;
    logic       host_rd_i = 1'b0;
    logic       bit_tick_i = 1'b0;
    logic [1:0] data_len_i = 2'd3;
    logic       parity_en_i = 1'b0;
    logic [1:0] stop_sel_i = 2'd0;
    logic       timeout_irq_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    rx_idle_timeout i_rx_idle_timeout (
        .clk (clk), .rst_n (rst_n), .fifo_nonempty_i (fifo_nonempty_i),
        .char_rcvd_i (char_rcvd_i), .host_rd_i (host_rd_i),
        .bit_tick_i (bit_tick_i), .data_len_i (data_len_i),
        .parity_en_i (parity_en_i), .stop_sel_i (stop_sel_i),
        .timeout_irq_o (timeout_irq_o)
    );

    // Vector: data_len code, parity, stop code, expected span in ticks (R2).
    typedef struct packed {
        logic [1:0] dl;
        logic       par;
        logic [1:0] stp;
        logic [7:0] span;
    } vec_t;
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd3, 1'b0, 2'd0, 8'd40},
        '{2'd0, 1'b0, 2'd0, 8'd28},
        '{2'd0, 1'b1, 2'd2, 8'd36},
        '{2'd3, 1'b1, 2'd1, 8'd48},
        '{2'd2, 1'b1, 2'd0, 8'd40},
        '{2'd1, 1'b0, 2'd3, 8'd36}
    };

    task automatic check(input logic got, input logic exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: irq=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) bit_tick_i = 1'b1;
            @(negedge clk) bit_tick_i = 1'b0;
        end
    endtask

    task automatic pulse_rd();
        @(negedge clk) host_rd_i = 1'b1;
        @(negedge clk) host_rd_i = 1'b0;
    endtask

    task automatic pulse_char();
        @(negedge clk) char_rcvd_i = 1'b1;
        @(negedge clk) char_rcvd_i = 1'b0;
    endtask

    task automatic set_fmt(input logic [1:0] dl, input logic par, input logic [1:0] stp);
        @(negedge clk);
        data_len_i = dl; parity_en_i = par; stop_sel_i = stp;
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(timeout_irq_o, 1'b0, "R10 reset state");

        // R1: ticks with empty FIFO do nothing, count held at zero.
        ticks(100);
        check(timeout_irq_o, 1'b0, "R1 empty fifo no irq");
        @(negedge clk) fifo_nonempty_i = 1'b1;
        ticks(39);
        check(timeout_irq_o, 1'b0, "R1 count held at zero while empty");
        ticks(1);
        check(timeout_irq_o, 1'b1, "R3 fires at 40 ticks");

        // Table walk over frame formats (R2, R3, R5).
        for (int v = 0; v < NV; v++) begin
            set_fmt(VECS[v].dl, VECS[v].par, VECS[v].stp);
            pulse_rd();
            check(timeout_irq_o, 1'b0, "R5 read clears irq");
            ticks(int'(VECS[v].span) - 1);
            check(timeout_irq_o, 1'b0, "R2 no irq one tick short");
            ticks(1);
            check(timeout_irq_o, 1'b1, "R2 irq at format span");
        end

        // R4: received character restarts the span.
        set_fmt(2'd3, 1'b0, 2'd0);
        pulse_rd();
        ticks(20);
        pulse_char();
        ticks(39);
        check(timeout_irq_o, 1'b0, "R4 char restarts count");
        ticks(1);
        check(timeout_irq_o, 1'b1, "R4 fires after full new span");

        // R7: sticky through ticks and a received character.
        ticks(5);
        check(timeout_irq_o, 1'b1, "R7 stays set over ticks");
        pulse_char();
        check(timeout_irq_o, 1'b1, "R7 char does not clear");

        // R5: host read mid-span restarts.
        pulse_rd();
        ticks(30);
        pulse_rd();
        ticks(39);
        check(timeout_irq_o, 1'b0, "R5 read restarts count");
        ticks(1);
        check(timeout_irq_o, 1'b1, "R5 fires after full new span");

        // R6: FIFO empty clears.
        @(negedge clk) fifo_nonempty_i = 1'b0;
        @(negedge clk);
        check(timeout_irq_o, 1'b0, "R6 empty clears irq");
        fifo_nonempty_i = 1'b1;

        // R8: restart in the same cycle as a tick wins.
        ticks(39);
        @(negedge clk) begin bit_tick_i = 1'b1; char_rcvd_i = 1'b1; end
        @(negedge clk) begin bit_tick_i = 1'b0; char_rcvd_i = 1'b0; end
        check(timeout_irq_o, 1'b0, "R8 restart beats tick");
        ticks(39);
        check(timeout_irq_o, 1'b0, "R8 tick was not counted");
        ticks(1);
        check(timeout_irq_o, 1'b1, "R8 fires after full span");

        // R9: shrink format below reached count, fire on next tick.
        pulse_rd();
        ticks(30);
        set_fmt(2'd0, 1'b0, 2'd0);
        @(negedge clk);
        check(timeout_irq_o, 1'b0, "R9 format change alone does not fire");
        ticks(1);
        check(timeout_irq_o, 1'b1, "R9 fires on next tick after shrink");

        // R10: reset mid-run clears flag.
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check(timeout_irq_o, 1'b0, "R10 reset clears irq");
        ticks(27);
        check(timeout_irq_o, 1'b0, "R10 count cleared by reset");
        ticks(1);
        check(timeout_irq_o, 1'b1, "R10 fires after full span from reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule